// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block is the buffer that sits behind a serial receiver in a 16550-style UART. The deserialiser hands it bytes one strobe at a time, and the host reads them back. It works in one of two modes. In queue mode a 16-entry first-in first-out store is used, with a selectable fill threshold. In single-register mode only one holding byte is kept. The block keeps the line-status flags that belong to reception: data ready, overrun and break.

In queue mode the block also detects a stalled receive stream. A counter runs on a one-cycle bit-period tick. If four character times pass with no new byte and no read that leaves data behind, and bytes are still waiting, the block raises a timeout-pending flag. The length of one character time comes from the frame format input. A control-register write enables or disables the queue, selects the threshold and flushes the store. Changing the enable bit also flushes it.

Top module: `uart_rxq`

## Requirements
- R1: After reset the block is in single-register mode with threshold selection 00. `level` is 0, `rd_data` is 0x00, and `data_ready`, `overrun`, `brk_flag`, `timeout_pend` and `trig_hit` are all 0.
- R2: In queue mode (last control write had bit 0 = 1), bytes leave in arrival order, up to 16 are held, and `level` gives the count. `rd_data` shows the oldest byte, or 0x00 when the queue is empty. A read of an empty queue returns 0x00 and changes nothing.
- R3: A byte that arrives while the queue is full and no read happens in the same cycle is dropped. The stored bytes are unchanged and `overrun` is set. A read and an arrival in the same cycle on a full queue are both accepted.
- R4: Control bits 7:6 pick the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. In queue mode `trig_hit` is `data_ready` and (`level` >= threshold). In single-register mode `trig_hit` equals `data_ready`.
- R5: A control write with bit 1 = 1, or with bit 0 different from the current mode, flushes the receive side. `level` goes to 0 and `data_ready`, `brk_flag` and `timeout_pend` go to 0. A byte arriving in the same cycle is dropped. Bit 2 (the transmit-side clear) has no effect here.
- R6: In single-register mode, a new byte replaces the held byte. If `data_ready` was already set and no read happens in the same cycle, `overrun` is set. A read clears `data_ready`. `level` is 1 when `data_ready` is set and 0 otherwise.
- R7: A break strobe stores the byte 0x00 as a received byte and sets both `brk_flag` and `data_ready`.
- R8: A read that leaves no data clears both `data_ready` and `brk_flag`.
- R9: A `lsr_rd` strobe clears `overrun` and `brk_flag`. If a new break or overrun occurs in the same cycle, the new one is kept.
- R10: One character time is 1 + (5 + `frame_cfg[1:0]`) + `frame_cfg[3]` + (`frame_cfg[2]` ? 2 : 1) bit ticks. The timeout fires on the 4 × that-number-th tick after the last restart.
- R11: In queue mode the timer restarts on each accepted byte and on each read that leaves data behind. If it expires while data is held, `timeout_pend` is set. A read or a flush clears `timeout_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| frame_cfg | input | 4 | Frame format: [1:0] data length − 5, [2] two stop bits, [3] parity on |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value: [0] queue enable, [1] receive flush, [2] transmit flush, [7:6] threshold |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | DW | Received byte |
| rx_break | input | 1 | Break condition received |
| rd_en | input | 1 | Host read of the receive data |
| lsr_rd | input | 1 | Host read of line status (clears overrun and break) |
| rd_data | output | DW | Byte returned by a read |
| level | output | clog2(DEPTH+1) | Bytes held |
| data_ready | output | 1 | Received data available |
| overrun | output | 1 | A byte was lost |
| brk_flag | output | 1 | A break was received |
| timeout_pend | output | 1 | Character timeout pending |
| trig_hit | output | 1 | Fill threshold reached |

## Verification
The bound checker checks these invariants on every cycle:
- the occupancy bound;
- data ready whenever bytes are held;
- timeout and threshold flags only alongside data ready;
- the effects one cycle after a break, a flush, a line-status read or an arrival into a full queue.

Some behaviour depends on the history of the run, and only the bench scenarios can show it:
- arrival ordering across wrap-around;
- each threshold setting;
- the single-register overwrite;
- the exact tick on which the timeout fires for two frame formats, and its restart after a partial read.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  // Bits per character: start + data + optional parity + stop bits.
  function automatic logic [3:0] frame_bits(input logic [3:0] cfg);
    logic [3:0] n;
    n = 4'd1 + 4'd5 + {2'b00, cfg[1:0]} + {3'b000, cfg[3]} + (cfg[2] ? 4'd2 : 4'd1);
    return n;
  endfunction

  // Fill threshold in bytes for a two-bit selection.
  function automatic logic [4:0] trig_count(input logic [1:0] sel);
    logic [4:0] t;
    case (sel)
      2'b00:   t = 5'd1;
      2'b01:   t = 5'd4;
      2'b10:   t = 5'd8;
      default: t = 5'd14;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = bump(wr_q);
      if (pop)  rd_d = bump(rd_q);
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_q] <= wdata;
  end

  assign rdata = (cnt_q != '0) ? mem[rd_q] : '0;
  assign count = cnt_q;
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int TMO_CHARS = 4,
  localparam int LIM_MAX  = TMO_CHARS * 12,
  localparam int TW       = $clog2(LIM_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] frame_cfg,
  input  logic       bit_tick,
  input  logic       restart,
  input  logic       stop,
  input  logic       rd_clear,
  input  logic       have_data,
  output logic       pend
);
  logic          run_q, run_d, pend_q, pend_d, expire;
  logic [TW-1:0] cnt_q, cnt_d, limit;

  assign limit  = TW'(TMO_CHARS) * TW'(uart_rxq_pkg::frame_bits(frame_cfg));
  assign expire = run_q && bit_tick && (cnt_q >= limit - TW'(1)) && !restart && !stop;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (stop) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (restart) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q && bit_tick) begin
      if (expire) begin
        run_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + TW'(1);
      end
    end
    if (expire && have_data) pend_d = 1'b1;
    if (stop || rd_clear)    pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq #(
  parameter int DEPTH     = 16,
  parameter int DW        = 8,
  parameter int TMO_CHARS = 4,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic [3:0]    frame_cfg,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_break,
  input  logic          rd_en,
  input  logic          lsr_rd,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] level,
  output logic          data_ready,
  output logic          overrun,
  output logic          brk_flag,
  output logic          timeout_pend,
  output logic          trig_hit
);
  logic          fen_q, fen_d;
  logic [1:0]    tsel_q, tsel_d;
  logic [DW-1:0] hold_q, hold_d, in_byte, st_rdata;
  logic          dr_q, dr_d, oe_q, oe_d, bi_q, bi_d;
  logic [CW-1:0] cnt, cnt_after;
  logic          flush, arrive, q_full, q_pop, q_push, restart;
  logic          unused_ctl;

  assign unused_ctl = ^{ctl_wdata[5:2]};

  assign flush     = ctl_we && (ctl_wdata[1] || (ctl_wdata[0] != fen_q));
  assign arrive    = rx_valid || rx_break;
  assign in_byte   = rx_break ? '0 : rx_data;
  assign q_full    = (cnt == CW'(DEPTH));
  assign q_pop     = fen_q && !flush && rd_en && (cnt != '0);
  assign q_push    = fen_q && !flush && arrive && (!q_full || q_pop);
  assign cnt_after = cnt - CW'(q_pop) + CW'(q_push);
  assign restart   = fen_q && !flush && (q_push || (rd_en && cnt_after != '0));

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(flush), .push(q_push), .pop(q_pop),
    .wdata(in_byte), .rdata(st_rdata), .count(cnt)
  );

  rxq_timeout #(.TMO_CHARS(TMO_CHARS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .frame_cfg(frame_cfg), .bit_tick(bit_tick),
    .restart(restart), .stop(flush), .rd_clear(rd_en),
    .have_data(cnt != '0), .pend(timeout_pend)
  );

  always_comb begin
    fen_d  = fen_q;
    tsel_d = tsel_q;
    hold_d = hold_q;
    dr_d   = dr_q;
    oe_d   = oe_q;
    bi_d   = bi_q;
    if (ctl_we) begin
      fen_d  = ctl_wdata[0];
      tsel_d = ctl_wdata[7:6];
    end
    if (lsr_rd) begin
      oe_d = 1'b0;
      bi_d = 1'b0;
    end
    if (flush) begin
      dr_d   = 1'b0;
      bi_d   = 1'b0;
      hold_d = '0;
    end else if (fen_q) begin
      if (arrive) begin
        dr_d = 1'b1;
        if (q_full && !q_pop) oe_d = 1'b1;
      end else if (rd_en && cnt_after == '0) begin
        dr_d = 1'b0;
        bi_d = 1'b0;
      end
    end else begin
      if (arrive) begin
        hold_d = in_byte;
        dr_d   = 1'b1;
        if (dr_q && !rd_en) oe_d = 1'b1;
      end else if (rd_en) begin
        dr_d = 1'b0;
        bi_d = 1'b0;
      end
    end
    if (!flush && rx_break) bi_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q  <= 1'b0;
      tsel_q <= 2'b00;
      hold_q <= '0;
      dr_q   <= 1'b0;
      oe_q   <= 1'b0;
      bi_q   <= 1'b0;
    end else begin
      fen_q  <= fen_d;
      tsel_q <= tsel_d;
      hold_q <= hold_d;
      dr_q   <= dr_d;
      oe_q   <= oe_d;
      bi_q   <= bi_d;
    end
  end

  assign rd_data    = fen_q ? st_rdata : hold_q;
  assign level      = fen_q ? cnt : CW'(dr_q);
  assign data_ready = dr_q;
  assign overrun    = oe_q;
  assign brk_flag   = bi_q;
  assign trig_hit   = dr_q && (!fen_q || (cnt >= CW'(uart_rxq_pkg::trig_count(tsel_q))));
endmodule

// File: rtl/uart_rxq_checker.sv
module uart_rxq_checker #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_break,
  input logic          rd_en,
  input logic          lsr_rd,
  input logic          ctl_we,
  input logic          ctl_clr,
  input logic [DW-1:0] rd_data,
  input logic [CW-1:0] level,
  input logic          data_ready,
  input logic          overrun,
  input logic          brk_flag,
  input logic          timeout_pend,
  input logic          trig_hit
);
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CW'(DEPTH) && rx_valid && !rx_break && !rd_en && !ctl_we)
    |=> (overrun && level == CW'(DEPTH) && $stable(rd_data)));

  p_trig_needs_dr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> data_ready);

  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_clr) |=> (level == '0 && !timeout_pend && !data_ready));

  p_break_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_break && !ctl_we) |=> (brk_flag && data_ready));

  p_dr_with_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |-> data_ready);

  p_lsr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_valid && !rx_break) |=> (!overrun && !brk_flag));

  p_pend_needs_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pend |-> data_ready);
endmodule

bind uart_rxq uart_rxq_checker #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_break(rx_break),
  .rd_en(rd_en), .lsr_rd(lsr_rd), .ctl_we(ctl_we), .ctl_clr(ctl_wdata[1]),
  .rd_data(rd_data), .level(level), .data_ready(data_ready),
  .overrun(overrun), .brk_flag(brk_flag), .timeout_pend(timeout_pend),
  .trig_hit(trig_hit)
);

// File: tb/sim_uart_rxq.sv
module sim_uart_rxq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic [3:0] frame_cfg = 4'b0011;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_break = 1'b0;
  logic       rd_en = 1'b0;
  logic       lsr_rd = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] level;
  logic       data_ready, overrun, brk_flag, timeout_pend, trig_hit;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_rxq u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_cfg(frame_cfg),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_break(rx_break), .rd_en(rd_en), .lsr_rd(lsr_rd),
    .rd_data(rd_data), .level(level), .data_ready(data_ready),
    .overrun(overrun), .brk_flag(brk_flag), .timeout_pend(timeout_pend),
    .trig_hit(trig_hit)
  );

  // Behavioural reference model
  logic [7:0] q[$];
  logic [7:0] m_hold = 8'h00;
  bit m_fen = 0, m_dr = 0, m_oe = 0, m_bi = 0, m_pend = 0, m_run = 0;
  bit [1:0] m_tsel = 2'b00;
  int m_ticks = 0;

  function automatic int thr(input bit [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_hold = 0; m_fen = 0; m_dr = 0; m_oe = 0; m_bi = 0;
      m_pend = 0; m_run = 0; m_ticks = 0; m_tsel = 0;
    end else begin
      automatic bit fl = ctl_we && (ctl_wdata[1] || (ctl_wdata[0] != m_fen));
      automatic bit arr = rx_valid || rx_break;
      automatic logic [7:0] b = rx_break ? 8'h00 : rx_data;
      automatic int lim = 4 * (1 + 5 + int'(frame_cfg[1:0]) + int'(frame_cfg[3]) + (frame_cfg[2] ? 2 : 1));
      automatic bit had = (q.size() != 0);
      automatic bit pushed = 0, rst_tmr = 0, expire = 0;
      if (lsr_rd) begin m_oe = 0; m_bi = 0; end
      if (fl) begin
        q.delete(); m_dr = 0; m_bi = 0; m_hold = 0; m_run = 0; m_ticks = 0; m_pend = 0;
      end else begin
        if (m_fen) begin
          if (rd_en && q.size() > 0) void'(q.pop_front());
          if (arr) begin
            if (q.size() < 16) begin q.push_back(b); pushed = 1; end
            else m_oe = 1;
            m_dr = 1;
          end else if (rd_en && q.size() == 0) begin
            m_dr = 0; m_bi = 0;
          end
          rst_tmr = pushed || (rd_en && q.size() > 0);
        end else begin
          if (arr) begin
            if (m_dr && !rd_en) m_oe = 1;
            m_hold = b; m_dr = 1;
          end else if (rd_en) begin
            m_dr = 0; m_bi = 0;
          end
        end
        if (rst_tmr) begin m_run = 1; m_ticks = 0; end
        else if (m_run && bit_tick) begin
          m_ticks++;
          if (m_ticks >= lim) begin m_run = 0; m_ticks = 0; expire = 1; end
        end
        if (expire && had) m_pend = 1;
        if (rd_en) m_pend = 0;
        if (rx_break) m_bi = 1;
      end
      if (ctl_we) begin m_fen = ctl_wdata[0]; m_tsel = ctl_wdata[7:6]; end
    end
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    automatic int e_rd = m_fen ? (q.size() != 0 ? int'(q[0]) : 0) : int'(m_hold);
    automatic int e_lv = m_fen ? q.size() : int'(m_dr);
    automatic int e_tr = m_dr && (!m_fen || q.size() >= thr(m_tsel));
    cmp("R2", "rd_data", rd_data, e_rd);
    cmp("R2", "level", level, e_lv);
    cmp("R8", "data_ready", data_ready, m_dr);
    cmp("R3", "overrun", overrun, m_oe);
    cmp("R7", "brk_flag", brk_flag, m_bi);
    cmp("R11", "timeout_pend", timeout_pend, m_pend);
    cmp("R4", "trig_hit", trig_hit, e_tr);
  endtask

  // Advance one cycle, compare against the model, drop all strobes.
  task automatic nxt();
    @(negedge clk);
    if (rst_n) compare_model();
    ctl_we = 0; rx_valid = 0; rx_break = 0; rd_en = 0; lsr_rd = 0; bit_tick = 0;
  endtask

  task automatic push(input logic [7:0] v);
    rx_valid = 1; rx_data = v; nxt();
  endtask

  task automatic ctl(input logic [7:0] v);
    ctl_we = 1; ctl_wdata = v; nxt();
  endtask

  task automatic rd();
    rd_en = 1; nxt();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin bit_tick = 1; nxt(); end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    nxt();
    // R1 reset state
    cmp("R1", "rd_data", rd_data, 0);
    cmp("R1", "level", level, 0);
    cmp("R1", "flags", {data_ready, overrun, brk_flag, timeout_pend, trig_hit}, 0);

    // R6 single-register mode
    push(8'hA5);
    cmp("R6", "rd_data", rd_data, 8'hA5);
    cmp("R6", "level", level, 1);
    push(8'h3C);
    cmp("R6", "overwrite", rd_data, 8'h3C);
    cmp("R6", "overrun", overrun, 1);
    rd();
    cmp("R6", "dr after read", data_ready, 0);
    cmp("R6", "level after read", level, 0);
    lsr_rd = 1; nxt();
    cmp("R9", "overrun cleared", overrun, 0);

    // R2 queue mode ordering
    ctl(8'h01);
    push(8'h11); push(8'h22); push(8'h33);
    cmp("R2", "level", level, 3);
    cmp("R2", "head", rd_data, 8'h11);
    rd();
    cmp("R2", "second", rd_data, 8'h22);
    rd(); rd();
    cmp("R8", "dr after drain", data_ready, 0);
    rd();
    cmp("R2", "empty read", rd_data, 0);

    // R3 full queue
    for (int i = 0; i < 17; i++) push(8'h40 + 8'(i));
    cmp("R3", "level full", level, 16);
    cmp("R3", "overrun", overrun, 1);
    cmp("R3", "head kept", rd_data, 8'h40);
    rd_en = 1; rx_valid = 1; rx_data = 8'h99; nxt();
    cmp("R3", "level read+push", level, 16);
    cmp("R3", "head after", rd_data, 8'h41);
    for (int i = 0; i < 15; i++) rd();
    cmp("R3", "tail byte", rd_data, 8'h99);
    rd();
    lsr_rd = 1; nxt();

    // R4 thresholds
    for (int s = 0; s < 4; s++) begin
      ctl(8'(s << 6) | 8'h03);
      for (int k = 1; k <= 14; k++) begin
        push(8'(k));
        cmp("R4", "trig_hit", trig_hit, (k >= thr(2'(s))) ? 1 : 0);
      end
    end

    // R5 flush with simultaneous arrival, then transmit clear ignored
    ctl_we = 1; ctl_wdata = 8'h03; rx_valid = 1; rx_data = 8'h55; nxt();
    cmp("R5", "level after flush", level, 0);
    cmp("R5", "dr after flush", data_ready, 0);
    push(8'h61); push(8'h62);
    ctl(8'h05);
    cmp("R5", "tx clear no effect", level, 2);
    cmp("R5", "head kept", rd_data, 8'h61);

    // R7 break, R8 read clears, R9 status read
    ctl(8'h03);
    rx_break = 1; nxt();
    cmp("R7", "break byte", rd_data, 0);
    cmp("R7", "brk/dr", {brk_flag, data_ready}, 2'b11);
    rd();
    cmp("R8", "brk/dr after read", {brk_flag, data_ready}, 2'b00);
    rx_break = 1; nxt();
    push(8'h77);
    lsr_rd = 1; nxt();
    cmp("R9", "brk cleared", brk_flag, 0);
    cmp("R9", "data kept", level, 2);

    // R10/R11 timeout, 8N1 = 10 bits -> 40 ticks
    ctl(8'h03);
    push(8'hA1); push(8'hA2);
    ticks(39);
    cmp("R10", "not yet", timeout_pend, 0);
    ticks(1);
    cmp("R10", "expired 40", timeout_pend, 1);
    rd();
    cmp("R11", "read clears", timeout_pend, 0);
    ticks(39);
    cmp("R11", "restart by read", timeout_pend, 0);
    ticks(1);
    cmp("R11", "expired after read", timeout_pend, 1);
    ctl(8'h03);
    cmp("R11", "flush clears", timeout_pend, 0);

    // R10 with parity, 8 data, 2 stop = 12 bits -> 48 ticks
    frame_cfg = 4'b1111;
    push(8'hB1);
    ticks(47);
    cmp("R10", "not yet 12b", timeout_pend, 0);
    ticks(1);
    cmp("R10", "expired 48", timeout_pend, 1);

    // R5 mode change flushes
    ctl(8'h00);
    cmp("R5", "disable flush", level, 0);
    push(8'hC3);
    cmp("R6", "single mode again", rd_data, 8'hC3);
    nxt();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule